// File: doc/BRIEF.md
# Six-Input Trigger Conditioning and Pattern Decision

This block turns six discriminated detector inputs into one global trigger decision. Each input runs through its own conditioning channel. The channel reacts only to a high-to-low transition of its input. It waits a programmable number of clock cycles and then holds a conditioned level high for a programmable number of cycles. Both counts are set separately for every channel, so pulses that arrive a few cycles apart can be made to overlap.

The six conditioned levels form a 6-bit index, with input 5 as the most significant bit. The index selects one bit of a 64-bit acceptance pattern. The pattern is loaded as two independent 32-bit words: the upper word holds indices 32 to 63 and the lower word holds indices 0 to 31.

- Every pattern bit that is 1 is an accepted combination, and the accepted combinations are OR-ed together.
- Each bit names a full combination of all six levels. An input that is 0 in an accepted combination therefore has to be inactive; it is a veto, not a don't-care.
- The lookup result is registered and re-evaluated on every cycle. A one-cycle trigger pulse is issued each time the registered result goes from 0 to 1.

Top module: `trig_pattern_unit`

## Requirements
- R1: After reset, `trig_o`, `trig_lvl_o` and `cond_o` are all 0. The pattern resets to upper word 0xFFFFFFFF and lower word 0xFFFEFFFE, so index 1 (only input 0 active) is accepted while index 16 (only input 4 active) and index 0 are not.
- R2: Only a falling transition (1 to 0) of an input starts conditioning. A rising transition, or an input held steady, never sets its `cond_o` bit.
- R3: With a delay of 0 and a stretch of S, `cond_o[i]` is high for exactly S cycles, starting in the first cycle after the clock edge that samples the falling input. A stretch of 0 keeps the channel inactive.
- R4: A delay of D > 0 postpones the start of the conditioned level by exactly D cycles; the stretch length is unchanged.
- R5: A new falling edge while the level is high reloads the stretch count, so the level stays high for S cycles counted from the new edge.
- R6: The lookup index is {cond_o[5], ..., cond_o[0]}. Upper-word bit j is pattern index 32+j and lower-word bit j is index j. `cond_o[i]` carries the conditioned level of `in_i[i]`.
- R7: A 0 in the pattern is a veto. With lower word 0x80000000 and upper word 0, a trigger occurs only for index 31 (inputs 0 to 4 active, input 5 inactive); index 63 gives none.
- R8: Several 1 bits in the pattern are OR-ed: each selected index produces a trigger, and any other index does not.
- R9: Setting bit 0 of the lower word makes the all-inactive combination (index 0) trigger.
- R10: `pat_hi_we` loads the upper word and `pat_lo_we` loads the lower word from `pat_wdata`, independently. A new word takes effect on the next cycle. `trig_lvl_o` is the pattern bit at the current index, registered one cycle after `cond_o`.
- R11: `trig_o` is high for exactly the first cycle in which `trig_lvl_o` is high. While the lookup stays 1 across index changes no new pulse is issued; a return to 1 after a 0 issues a new pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for all logic |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_i | input | 6 | Discriminated detector inputs, synchronous to clk |
| delay_cfg | input | 30 | Per-channel delay, 5 bits per channel, channel i in bits [5i+4:5i] |
| stretch_cfg | input | 30 | Per-channel stretch length, same packing as delay_cfg |
| pat_hi_we | input | 1 | Load upper pattern word (indices 32-63) |
| pat_lo_we | input | 1 | Load lower pattern word (indices 0-31) |
| pat_wdata | input | 32 | Pattern word data |
| cond_o | output | 6 | Conditioned levels, also the lookup index |
| trig_lvl_o | output | 1 | Registered lookup result |
| trig_o | output | 1 | One-cycle global trigger pulse |

## Verification
Two counts decide every expected time. Let c be the cycle in which an input is driven low. The conditioned bit appears in cycle c+1+D and drops after S cycles. The trigger pulse and the lookup level appear one cycle after the conditioned index changes, which is cycle c+2+D for a single edge. A pattern write driven in cycle c changes the lookup result in cycle c+2.

The driver tasks compute these cycle numbers from the requirements and push each expected pulse, with the index expected at that moment, into a queue. A monitor samples on the falling clock edge, so it reads values settled after the rising edge. It pops the queue entry on every pulse and compares the cycle number exactly, and it reports any pulse that is unplanned or a second cycle long. Conditioned levels are checked directly just before and just after each computed start and end cycle.

// File: rtl/trg_pkg.sv
package trg_pkg;
    localparam int NUM_IN     = 6;
    localparam int WORD_W     = 32;
    localparam int PAT_W      = 1 << NUM_IN;
    localparam int CNT_W      = 5;

    localparam logic [WORD_W-1:0] PAT_HI_RST = 32'hFFFF_FFFF;
    localparam logic [WORD_W-1:0] PAT_LO_RST = 32'hFFFE_FFFE;

    typedef struct packed {
        logic [PAT_W-1:0] pat;
        logic             lvl;
        logic             trig;
    } lut_st_t;
endpackage

// File: rtl/trg_chan_cond.sv
module trg_chan_cond #(
    parameter int CW = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          in_i,
    input  logic [CW-1:0] delay_i,
    input  logic [CW-1:0] stretch_i,
    output logic          level_o
);
    typedef struct packed {
        logic          in_prev;
        logic [CW-1:0] dly;
        logic [CW-1:0] str;
    } chan_st_t;

    localparam logic [CW-1:0] ONE = CW'(1);

    chan_st_t st_d, st_q;
    logic     fall;
    logic     fire;

    always_comb begin
        st_d         = st_q;
        st_d.in_prev = in_i;
        fall         = st_q.in_prev & ~in_i;
        fire         = 1'b0;
        if (st_q.dly != '0) begin
            st_d.dly = st_q.dly - ONE;
        end
        if (st_q.dly == ONE) begin
            fire = 1'b1;
        end
        if (fall) begin
            if (delay_i == '0) begin
                fire = 1'b1;
            end else begin
                st_d.dly = delay_i;
            end
        end
        if (fire) begin
            st_d.str = stretch_i;
        end else if (st_q.str != '0) begin
            st_d.str = st_q.str - ONE;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign level_o = (st_q.str != '0);

    // R2: with no pending delay, no level and no falling edge, the level stays low
    a_r2_no_edge_no_level: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.dly == '0 && st_q.str == '0 && !fall) |=> !level_o);

    // R4: an expiring delay starts the stretch
    a_r4_delay_starts: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.dly == ONE && stretch_i != '0) |=> level_o);

    // R5: an undelayed edge reloads the full stretch count
    a_r5_reload: assert property (@(posedge clk) disable iff (!rst_n)
        (fall && delay_i == '0) |=> (st_q.str == $past(stretch_i)));

    // R3: without a reload the stretch counts down by one
    a_r3_count_down: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.str != '0 && !fall && st_q.dly != ONE) |=> (st_q.str == $past(st_q.str) - ONE));
endmodule

// File: rtl/trg_pattern_lut.sv
module trg_pattern_lut
    import trg_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_IN-1:0] idx_i,
    input  logic              hi_we,
    input  logic              lo_we,
    input  logic [WORD_W-1:0] wdata,
    output logic              lvl_o,
    output logic              trig_o
);
    localparam int HI_LSB = PAT_W - WORD_W;

    lut_st_t st_d, st_q;
    logic    hit;

    always_comb begin
        st_d = st_q;
        hit  = st_q.pat[idx_i];
        if (hi_we) begin
            st_d.pat[PAT_W-1:HI_LSB] = wdata;
        end
        if (lo_we) begin
            st_d.pat[WORD_W-1:0] = wdata;
        end
        st_d.lvl  = hit;
        st_d.trig = hit & ~st_q.lvl;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.pat  <= {PAT_HI_RST, PAT_LO_RST};
            st_q.lvl  <= 1'b0;
            st_q.trig <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign lvl_o  = st_q.lvl;
    assign trig_o = st_q.trig;

    // R11: the trigger pulse lasts one cycle
    a_r11_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        trig_o |=> !trig_o);

    // R11: a pulse only accompanies a high lookup level
    a_r11_with_level: assert property (@(posedge clk) disable iff (!rst_n)
        trig_o |-> lvl_o);

    // R10: a lower-word write lands in the pattern
    a_r10_lo_write: assert property (@(posedge clk) disable iff (!rst_n)
        lo_we |=> (st_q.pat[WORD_W-1:0] == $past(wdata)));

    // R10: an upper-word write lands in the pattern
    a_r10_hi_write: assert property (@(posedge clk) disable iff (!rst_n)
        hi_we |=> (st_q.pat[PAT_W-1:HI_LSB] == $past(wdata)));
endmodule

// File: rtl/trig_pattern_unit.sv
module trig_pattern_unit
    import trg_pkg::*;
#(
    parameter int CNT_W_P = CNT_W,
    localparam int CFG_W  = NUM_IN * CNT_W_P
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_IN-1:0] in_i,
    input  logic [CFG_W-1:0]  delay_cfg,
    input  logic [CFG_W-1:0]  stretch_cfg,
    input  logic              pat_hi_we,
    input  logic              pat_lo_we,
    input  logic [WORD_W-1:0] pat_wdata,
    output logic [NUM_IN-1:0] cond_o,
    output logic              trig_lvl_o,
    output logic              trig_o
);
    logic [NUM_IN-1:0] cond;

    for (genvar g = 0; g < NUM_IN; g++) begin : g_chan
        trg_chan_cond #(
            .CW (CNT_W_P)
        ) u_chan (
            .clk       (clk),
            .rst_n     (rst_n),
            .in_i      (in_i[g]),
            .delay_i   (delay_cfg[g*CNT_W_P +: CNT_W_P]),
            .stretch_i (stretch_cfg[g*CNT_W_P +: CNT_W_P]),
            .level_o   (cond[g])
        );
    end

    trg_pattern_lut u_lut (
        .clk    (clk),
        .rst_n  (rst_n),
        .idx_i  (cond),
        .hi_we  (pat_hi_we),
        .lo_we  (pat_lo_we),
        .wdata  (pat_wdata),
        .lvl_o  (trig_lvl_o),
        .trig_o (trig_o)
    );

    assign cond_o = cond;

    // R11: a pulse needs the lookup level to have been low the cycle before
    a_r11_rise_only: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(trig_o) |-> $past(!trig_lvl_o));
endmodule

// File: tb/trig_pattern_unit_bench.sv
module trig_pattern_unit_bench;
    typedef struct {
        int         cyc;
        logic [5:0] idx;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [5:0]  in_r = 6'h3F;
    logic [29:0] dly_cfg = '0;
    logic [29:0] str_cfg = '0;
    logic        hi_we = 1'b0;
    logic        lo_we = 1'b0;
    logic [31:0] wdata = '0;
    logic [5:0]  cond_o;
    logic        trig_lvl_o;
    logic        trig_o;

    int   cyc = 0;
    int   checks = 0;
    int   errors = 0;
    logic prev_trig = 1'b0;
    exp_t expq[$];

    always #10 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    trig_pattern_unit u_trig_pattern_unit (
        .clk         (clk),
        .rst_n       (rst_n),
        .in_i        (in_r),
        .delay_cfg   (dly_cfg),
        .stretch_cfg (str_cfg),
        .pat_hi_we   (hi_we),
        .pat_lo_we   (lo_we),
        .pat_wdata   (wdata),
        .cond_o      (cond_o),
        .trig_lvl_o  (trig_lvl_o),
        .trig_o      (trig_o)
    );

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual %0h expected %0h (cycle %0d)", tag, act, exp, cyc);
        end
    endtask

    task automatic push(input int c, input logic [5:0] idx);
        exp_t e;
        e.cyc = c;
        e.idx = idx;
        expq.push_back(e);
    endtask

    task automatic set_ch(input int ch, input int d, input int s);
        dly_cfg[ch*5 +: 5] = 5'(d);
        str_cfg[ch*5 +: 5] = 5'(s);
    endtask

    task automatic drop(input logic [5:0] m, output int c);
        @(negedge clk);
        in_r = in_r & ~m;
        c = cyc;
    endtask

    task automatic lift(input logic [5:0] m);
        @(negedge clk);
        in_r = in_r | m;
    endtask

    task automatic wr(input bit hi, input logic [31:0] v, output int c);
        @(negedge clk);
        hi_we = hi;
        lo_we = !hi;
        wdata = v;
        c = cyc;
        @(negedge clk);
        hi_we = 1'b0;
        lo_we = 1'b0;
    endtask

    task automatic idle(input int n);
        for (int k = 0; k < n; k++) @(negedge clk);
    endtask

    task automatic wait_to(input int c);
        while (cyc < c) @(negedge clk);
    endtask

    // Scoreboard monitor
    always @(negedge clk) begin
        if (rst_n) begin
            if (trig_o && prev_trig) begin
                checks++;
                errors++;
                $display("FAIL R11 pulse longer than one cycle actual 1 expected 0 (cycle %0d)", cyc);
            end
            if (trig_o) begin
                checks++;
                if (expq.size() == 0) begin
                    errors++;
                    $display("FAIL R1 R7 R8 unexpected trigger actual 1 expected 0 (cycle %0d idx %0h)", cyc, cond_o);
                end else begin
                    exp_t e;
                    e = expq.pop_front();
                    if (e.cyc != cyc || e.idx != cond_o || !trig_lvl_o) begin
                        errors++;
                        $display("FAIL R11 trigger actual cycle %0d idx %0h lvl %0b expected cycle %0d idx %0h lvl 1",
                                 cyc, cond_o, trig_lvl_o, e.cyc, e.idx);
                    end
                end
            end
            prev_trig <= trig_o;
        end
    end

    initial begin
        int c;
        int t;
        for (int ch = 0; ch < 6; ch++) set_ch(ch, 0, 3);
        idle(3);
        rst_n = 1'b1;
        idle(3);
        // R1: reset state
        chk("R1 trig_o", trig_o, 0);
        chk("R1 trig_lvl_o", trig_lvl_o, 0);
        chk("R1 cond_o", cond_o, 0);

        // R1 R3 R6: input 0 alone with default pattern, stretch 3
        drop(6'h01, c);
        push(c + 2, 6'h01);
        @(negedge clk); chk("R3 start", cond_o, 6'h01);
        wait_to(c + 3); chk("R3 last", cond_o, 6'h01);
        wait_to(c + 4); chk("R3 end", cond_o, 6'h00);
        // R2: rising edge does not start conditioning
        lift(6'h01);
        @(negedge clk); chk("R2 rise c+1", cond_o, 6'h00);
        @(negedge clk); chk("R2 rise c+2", cond_o, 6'h00);
        idle(4);

        // R1 R6: input 4 alone, index 16 rejected by default pattern
        drop(6'h10, c);
        @(negedge clk); chk("R6 index16", cond_o, 6'h10);
        idle(6);
        chk("R1 index16 no level", trig_lvl_o, 0);
        lift(6'h10);
        idle(4);

        // R4: delay 4, stretch 2 on input 1
        set_ch(1, 4, 2);
        drop(6'h02, c);
        push(c + 6, 6'h02);
        wait_to(c + 4); chk("R4 before", cond_o, 6'h00);
        wait_to(c + 5); chk("R4 start", cond_o, 6'h02);
        wait_to(c + 6); chk("R4 last", cond_o, 6'h02);
        wait_to(c + 7); chk("R4 end", cond_o, 6'h00);
        lift(6'h02);
        set_ch(1, 0, 3);
        idle(4);

        // R5: retrigger during stretch on input 2
        set_ch(2, 0, 5);
        drop(6'h04, c);
        push(c + 2, 6'h04);
        lift(6'h04);
        wait_to(c + 2);
        @(negedge clk); in_r = in_r & ~6'h04;
        wait_to(c + 8); chk("R5 extended", cond_o, 6'h04);
        wait_to(c + 9); chk("R5 end", cond_o, 6'h00);
        lift(6'h04);
        idle(4);

        // R7 R10: veto pattern
        for (int ch = 0; ch < 6; ch++) set_ch(ch, 0, 4);
        wr(1'b0, 32'h8000_0000, t);
        wr(1'b1, 32'h0000_0000, t);
        idle(2);
        drop(6'h1F, c);
        push(c + 2, 6'h1F);
        idle(3);
        lift(6'h1F);
        idle(6);
        drop(6'h3F, c);
        @(negedge clk); chk("R7 index63", cond_o, 6'h3F);
        @(negedge clk); chk("R7 veto level", trig_lvl_o, 0);
        lift(6'h3F);
        idle(6);

        // R8: OR of indices 3 and 5
        wr(1'b0, 32'h0000_0028, t);
        idle(2);
        drop(6'h03, c);
        push(c + 2, 6'h03);
        lift(6'h03);
        idle(6);
        drop(6'h05, c);
        push(c + 2, 6'h05);
        lift(6'h05);
        idle(6);
        drop(6'h01, c);
        @(negedge clk);
        @(negedge clk); chk("R8 index1 rejected", trig_lvl_o, 0);
        lift(6'h01);
        idle(6);

        // R11: re-evaluation, index 3 (rejected) decays to index 1 (accepted)
        wr(1'b0, 32'h0000_0002, t);
        set_ch(0, 0, 10);
        set_ch(1, 0, 3);
        idle(2);
        drop(6'h03, c);
        push(c + 5, 6'h01);
        wait_to(c + 4); chk("R11 no level yet", trig_lvl_o, 0);
        lift(6'h03);
        idle(12);
        set_ch(0, 0, 4);
        set_ch(1, 0, 4);

        // R3: stretch 0 keeps channel inactive
        wr(1'b0, 32'h0000_0010, t);
        set_ch(2, 0, 0);
        idle(2);
        drop(6'h04, c);
        @(negedge clk); chk("R3 zero stretch c+1", cond_o, 6'h00);
        @(negedge clk); chk("R3 zero stretch c+2", cond_o, 6'h00);
        lift(6'h04);
        idle(4);

        // R9 R10: bit 0 triggers with all inputs inactive
        wr(1'b0, 32'h0000_0001, c);
        push(c + 2, 6'h00);
        wait_to(c + 1); chk("R10 not yet", trig_lvl_o, 0);
        wait_to(c + 4); chk("R9 level", trig_lvl_o, 1);
        wr(1'b0, 32'h0000_0000, c);
        wait_to(c + 2); chk("R10 cleared", trig_lvl_o, 0);
        idle(4);

        chk("R11 all expected pulses seen", expq.size(), 0);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(20 * 20000);
        checks++;
        errors++;
        $display("FAIL watchdog expired actual timeout expected completion");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule